// File: doc/BRIEF.md
# Inter-Processor Interrupt Unit

A shared block through which any of `NUM_CORES` cores (default 4) can raise an interrupt on another core. Each core owns one command lane, and the lane index is the identity of the core issuing the command. A command has an operation code and a core-number parameter. For each target core the block keeps a pending-sender bitmap with one bit per core that has signalled it. The block drives one interrupt line per core, and each lane has its own readback register that returns the result of its latest query.

A sender can first ask whether its target already has an interrupt pending, then raise one. The receiving core takes its interrupt, asks which cores sent it, and acknowledges each sender separately. Requests from several senders that reach one target close together are merged into a single asserted line, and the source bitmap then shows every sender.

Each core's line is driven by a two-state machine, `LINE_QUIET` and `LINE_RAISED`. The `raise` transition moves from quiet to raised when the core's bitmap, as registered, is nonzero. The `drop` transition moves back to quiet when the bitmap is zero. The `hold` transition covers every other case and keeps the current state.

Top module: `ipi_unit`

## Requirements
- R1: After reset every interrupt line is low and every readback register is zero.
- R2: An operation code of 1 (raise) on lane s with parameter t, where t differs from s, sets bit s of core t's bitmap at the next clock edge. Core t's line goes high one edge after that.
- R3: A raise whose parameter equals its own lane number changes no bitmap and no line.
- R4: An operation code of 2 (peek) with parameter t loads the lane's readback at the next edge. Bit 0 is 1 when core t's bitmap was nonzero before that edge, and all upper bits are 0.
- R5: An operation code of 3 (who) loads the lane's readback at the next edge with the lane's own bitmap, where bit s set means core s sent an interrupt.
- R6: Raises from several lanes to one target in the same cycle set several bits, and that target still has a single line.
- R7: An operation code of 4 (clear) on lane t with parameter s clears only bit s of core t's bitmap.
- R8: A core's line stays high while any bit of its bitmap is set and goes low one edge after the last bit is cleared.
- R9: When a raise and a clear hit the same bitmap bit in the same cycle, the bit ends up set.
- R10: Operation codes 0, 5, 6 and 7, and any command with valid low, change no bitmap and no readback.
- R11: A lane's readback holds its value in every cycle in which that lane issues no peek or who.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | NUM_CORES | Per-lane command strobe |
| cmd_op | input | NUM_CORES x 3 | Per-lane operation code |
| cmd_arg | input | NUM_CORES x ID_W | Per-lane core-number parameter |
| irq | output | NUM_CORES | Interrupt line per core |
| readback | output | NUM_CORES x NUM_CORES | Per-lane query result |

## Verification
The bench builds the block with its default of four cores. With four cores and a two-bit parameter, every parameter value names a real core, so every self-target, every pairing of sender and target, and every three-way merge into one bitmap can be reached. Four cores also bring the 4'b1011 merged bitmap and simultaneous raise-against-clear collisions within reach of a short random run.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

    typedef enum logic [2:0] {
        OP_IDLE  = 3'd0,
        OP_RAISE = 3'd1,
        OP_PEEK  = 3'd2,
        OP_WHO   = 3'd3,
        OP_CLEAR = 3'd4
    } ipi_op_e;

    typedef enum logic {
        LINE_QUIET  = 1'b0,
        LINE_RAISED = 1'b1
    } line_state_e;

endpackage

// File: rtl/ipi_cmd_decode.sv
module ipi_cmd_decode
    import ipi_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int ID_W      = 2,
    parameter int SELF      = 0
) (
    input  logic                 valid,
    input  logic [2:0]           op,
    input  logic [ID_W-1:0]      arg,
    output logic [NUM_CORES-1:0] raise_tgt,
    output logic [NUM_CORES-1:0] clear_src,
    output logic                 peek,
    output logic                 who
);

    logic is_raise;
    logic is_clear;

    always_comb begin
        is_raise = valid && (op == OP_RAISE);
        is_clear = valid && (op == OP_CLEAR);
        peek     = valid && (op == OP_PEEK);
        who      = valid && (op == OP_WHO);
    end

    for (genvar k = 0; k < NUM_CORES; k++) begin : g_sel
        if (k == SELF) begin : g_self
            assign raise_tgt[k] = 1'b0;
        end else begin : g_other
            assign raise_tgt[k] = is_raise && (arg == ID_W'(k));
        end
        assign clear_src[k] = is_clear && (arg == ID_W'(k));
    end

endmodule

// File: rtl/ipi_sender_bank.sv
module ipi_sender_bank #(
    parameter int NUM_CORES = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [NUM_CORES-1:0][NUM_CORES-1:0] set_m,
    input  logic [NUM_CORES-1:0][NUM_CORES-1:0] clr_m,
    output logic [NUM_CORES-1:0][NUM_CORES-1:0] pend
);

    for (genvar t = 0; t < NUM_CORES; t++) begin : g_tgt
        for (genvar s = 0; s < NUM_CORES; s++) begin : g_src
            always_ff @(posedge clk) begin
                if (!rst_n)
                    pend[t][s] <= 1'b0;
                else if (set_m[t][s])
                    pend[t][s] <= 1'b1;
                else if (clr_m[t][s])
                    pend[t][s] <= 1'b0;
            end

            p_raise_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
                set_m[t][s] |=> pend[t][s]);
            p_clear_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_m[t][s] && !set_m[t][s]) |=> !pend[t][s]);
            p_raise_beats_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_m[t][s] && set_m[t][s]) |=> pend[t][s]);
            p_idle_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
                (!clr_m[t][s] && !set_m[t][s]) |=> $stable(pend[t][s]));
        end
    end

endmodule

// File: rtl/ipi_line_fsm.sv
module ipi_line_fsm
    import ipi_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CORES-1:0] senders,
    output logic                 irq
);

    line_state_e state_q;
    line_state_e state_d;
    logic        any_sender;

    assign any_sender = |senders;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINE_QUIET:  if (any_sender)  state_d = LINE_RAISED;
            LINE_RAISED: if (!any_sender) state_d = LINE_QUIET;
            default:     state_d = LINE_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= LINE_QUIET;
        else
            state_q <= state_d;
    end

    always_comb begin
        irq = (state_q == LINE_RAISED);
    end

    p_line_up_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|senders) |=> irq);
    p_line_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(|senders) |=> !irq);

endmodule

// File: rtl/ipi_readback.sv
module ipi_readback #(
    parameter int NUM_CORES = 4,
    parameter int ID_W      = 2
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                peek,
    input  logic                                who,
    input  logic [ID_W-1:0]                     arg,
    input  logic [NUM_CORES-1:0]                own,
    input  logic [NUM_CORES-1:0]                any_pend,
    output logic [NUM_CORES-1:0]                rb
);

    logic [NUM_CORES-1:0] rb_d;

    always_comb begin
        rb_d = rb;
        unique case ({peek, who})
            2'b10:   rb_d = {{(NUM_CORES-1){1'b0}}, any_pend[arg]};
            2'b01:   rb_d = own;
            default: rb_d = rb;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rb <= '0;
        else
            rb <= rb_d;
    end

    p_rb_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(peek || who) |=> $stable(rb));
    p_peek_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        peek |=> (rb[NUM_CORES-1:1] == '0));
    p_who_copies_r5: assert property (@(posedge clk) disable iff (!rst_n)
        who |=> (rb == $past(own)));

endmodule

// File: rtl/ipi_unit.sv
module ipi_unit
    import ipi_pkg::*;
#(
    parameter int NUM_CORES = 4,
    localparam int ID_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [NUM_CORES-1:0]                cmd_valid,
    input  logic [NUM_CORES-1:0][2:0]           cmd_op,
    input  logic [NUM_CORES-1:0][ID_W-1:0]      cmd_arg,
    output logic [NUM_CORES-1:0]                irq,
    output logic [NUM_CORES-1:0][NUM_CORES-1:0] readback
);

    logic [NUM_CORES-1:0][NUM_CORES-1:0] raise_l;
    logic [NUM_CORES-1:0][NUM_CORES-1:0] clear_l;
    logic [NUM_CORES-1:0][NUM_CORES-1:0] set_m;
    logic [NUM_CORES-1:0][NUM_CORES-1:0] pend;
    logic [NUM_CORES-1:0]                peek_l;
    logic [NUM_CORES-1:0]                who_l;
    logic [NUM_CORES-1:0]                any_pend;

    for (genvar l = 0; l < NUM_CORES; l++) begin : g_lane
        ipi_cmd_decode #(
            .NUM_CORES (NUM_CORES),
            .ID_W      (ID_W),
            .SELF      (l)
        ) u_dec (
            .valid     (cmd_valid[l]),
            .op        (cmd_op[l]),
            .arg       (cmd_arg[l]),
            .raise_tgt (raise_l[l]),
            .clear_src (clear_l[l]),
            .peek      (peek_l[l]),
            .who       (who_l[l])
        );

        for (genvar t = 0; t < NUM_CORES; t++) begin : g_xpose
            assign set_m[t][l] = raise_l[l][t];
        end

        assign any_pend[l] = |pend[l];

        ipi_readback #(
            .NUM_CORES (NUM_CORES),
            .ID_W      (ID_W)
        ) u_rb (
            .clk      (clk),
            .rst_n    (rst_n),
            .peek     (peek_l[l]),
            .who      (who_l[l]),
            .arg      (cmd_arg[l]),
            .own      (pend[l]),
            .any_pend (any_pend),
            .rb       (readback[l])
        );

        ipi_line_fsm #(
            .NUM_CORES (NUM_CORES)
        ) u_line (
            .clk     (clk),
            .rst_n   (rst_n),
            .senders (pend[l]),
            .irq     (irq[l])
        );

        p_no_self_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_valid[l] && cmd_op[l] == OP_RAISE && cmd_arg[l] == ID_W'(l))
                |=> !pend[l][l]);
    end

    ipi_sender_bank #(
        .NUM_CORES (NUM_CORES)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .set_m (set_m),
        .clr_m (clear_l),
        .pend  (pend)
    );

endmodule

// File: tb/ipi_unit_test.sv
`timescale 1ns/1ps
module ipi_unit_test;

    localparam int N  = 4;
    localparam int IW = 2;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [N-1:0]          cmd_valid;
    logic [N-1:0][2:0]     cmd_op;
    logic [N-1:0][IW-1:0]  cmd_arg;
    logic [N-1:0]          irq;
    logic [N-1:0][N-1:0]   readback;

    ipi_unit #(.NUM_CORES(N)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_arg   (cmd_arg),
        .irq       (irq),
        .readback  (readback)
    );

    always #10 clk = ~clk;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 1'b0;
    string tag      = "R1";

    logic         bv  [N];
    logic [2:0]   bop [N];
    logic [IW-1:0] bar [N];
    logic [N-1:0] m_bm   [N];
    logic [N-1:0] m_rb   [N];
    logic         m_irq  [N];

    task automatic check(input string t, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", t, act, exp);
        end
    endtask

    task automatic idle_inputs();
        for (int l = 0; l < N; l++) begin
            bv[l] = 1'b0; bop[l] = 3'd0; bar[l] = '0;
            cmd_valid[l] = 1'b0; cmd_op[l] = 3'd0; cmd_arg[l] = '0;
        end
    endtask

    function automatic logic [N-1:0] next_rb(input int l);
        if (bv[l] && bop[l] == 3'd2) return {{(N-1){1'b0}}, (m_bm[bar[l]] != '0)};
        if (bv[l] && bop[l] == 3'd3) return m_bm[l];
        return m_rb[l];
    endfunction

    function automatic logic next_bit(input int t, input int s);
        logic g, a;
        g = bv[s] && bop[s] == 3'd1 && int'(bar[s]) == t && s != t;
        a = bv[t] && bop[t] == 3'd4 && int'(bar[t]) == s;
        if (g) return 1'b1;
        if (a) return 1'b0;
        return m_bm[t][s];
    endfunction

    // One clock: drive the staged commands at a falling edge, advance the model
    // at the rising edge, compare at the next falling edge, then go idle.
    task automatic cycle();
        logic [N-1:0] nbm [N];
        logic [N-1:0] nrb [N];
        for (int l = 0; l < N; l++) begin
            cmd_valid[l] = bv[l]; cmd_op[l] = bop[l]; cmd_arg[l] = bar[l];
        end
        for (int t = 0; t < N; t++) begin
            nrb[t] = next_rb(t);
            for (int s = 0; s < N; s++) nbm[t][s] = next_bit(t, s);
        end
        @(posedge clk);
        for (int t = 0; t < N; t++) begin
            m_irq[t] = (m_bm[t] != '0);
            m_bm[t]  = nbm[t];
            m_rb[t]  = nrb[t];
        end
        @(negedge clk);
        for (int l = 0; l < N; l++) begin
            check({tag, " irq (R8)"}, {{(N-1){1'b0}}, irq[l]}, {{(N-1){1'b0}}, m_irq[l]});
            check({tag, " readback"}, readback[l], m_rb[l]);
        end
        idle_inputs();
    endtask

    task automatic cmd(input int l, input int op, input int a);
        bv[l] = 1'b1; bop[l] = 3'(op); bar[l] = IW'(a);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'h1F2E3D4C));
        idle_inputs();
        for (int l = 0; l < N; l++) begin
            m_bm[l] = '0; m_rb[l] = '0; m_irq[l] = 1'b0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        tag = "R1";
        check("R1 irq after reset", irq, '0);
        for (int l = 0; l < N; l++) check("R1 readback after reset", readback[l], '0);

        // R2: core 1 raises core 2, line follows one edge later
        tag = "R2";
        cmd(1, 1, 2); cycle();
        check("R2 line not yet high", {3'b0, irq[2]}, 4'b0000);
        cycle();
        check("R2 line high", {3'b0, irq[2]}, 4'b0001);

        // R3: core 0 raises itself
        tag = "R3";
        cmd(0, 1, 0); cycle();
        cmd(0, 3, 0); cycle();
        check("R3 self raise ignored", readback[0], 4'b0000);
        check("R3 line 0 low", {3'b0, irq[0]}, 4'b0000);

        // R4: peek
        tag = "R4";
        cmd(3, 2, 2); cycle();
        check("R4 peek pending target", readback[3], 4'b0001);
        cmd(3, 2, 0); cycle();
        check("R4 peek idle target", readback[3], 4'b0000);

        // R6 / R5: merge two more senders
        tag = "R6";
        cmd(0, 1, 2); cmd(3, 1, 2); cycle();
        cmd(2, 3, 0); cycle();
        check("R5 R6 merged source bitmap", readback[2], 4'b1011);
        check("R6 single line", irq, 4'b0100);

        // R7: clear sender 1 only
        tag = "R7";
        cmd(2, 4, 1); cycle();
        cmd(2, 3, 0); cycle();
        check("R7 only bit 1 cleared", readback[2], 4'b1001);
        check("R8 line stays with bits left", {3'b0, irq[2]}, 4'b0001);

        // R9: raise and clear on the same bit
        tag = "R9";
        cmd(1, 1, 2); cmd(2, 4, 1); cycle();
        cmd(2, 3, 0); cycle();
        check("R9 raise wins", readback[2], 4'b1011);

        // R8: clear all, line drops one edge after the last clear
        tag = "R8";
        cmd(2, 4, 0); cycle();
        cmd(2, 4, 1); cycle();
        cmd(2, 4, 3); cycle();
        check("R8 line held on last-clear edge", {3'b0, irq[2]}, 4'b0001);
        cycle();
        check("R8 line dropped", {3'b0, irq[2]}, 4'b0000);

        // R10 / R11: unknown codes and idle lanes
        tag = "R10";
        cmd(0, 1, 1); cycle();
        cmd(1, 3, 0); cycle();
        for (int c = 5; c < 8; c++) begin
            cmd(0, c, 1); cmd(1, c, 0); cycle();
        end
        cmd(1, 0, 2); cycle();
        bv[1] = 1'b0; bop[1] = 3'd4; bar[1] = 2'd0; cycle();
        check("R11 readback held", readback[1], 4'b0001);
        cmd(1, 3, 0); cycle();
        check("R10 bitmap unchanged", readback[1], 4'b0001);

        // Random mix
        tag = "R2 R7 random";
        for (int i = 0; i < 3000; i++) begin
            for (int l = 0; l < N; l++) begin
                bv[l]  = ($urandom % 3) != 0;
                bop[l] = 3'($urandom % 8);
                bar[l] = IW'($urandom % N);
            end
            cycle();
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule